// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block drives the memory side of a multi-register load or store for a processor with sixteen general registers and 32-bit words. A one-cycle start pulse brings in a 16-bit selection mask, a base address, the direction and timing of the address step, the transfer kind and a base-update enable. The sequencer then produces one word request for each selected register, with a ready/valid handshake toward memory.

The sequencer first works out the lowest address the transfer will touch. It then walks the selected registers from the lowest index upward, and the address rises by one word at each accepted beat. This holds in the decrementing modes too. Each request carries the register index, the word address, a write flag and a flag that marks it as part of a sequential burst. When the last beat is accepted, the block pulses a completion signal and presents the new base value, with a strobe when the base is to be written back.

An optional stack selector lets software name a push or a pop on one of four stack types, and the sequencer picks the matching address mode.

Top module: `blkxfer_seq`

## Requirements
- R1: One request is issued for each set bit of `mask_i` (bit i selects register i). Requests appear in ascending register order, and `req_reg_o` carries the register index.
- R2: With n set bits and 4-byte words, the first request address is base for increment-after (`incr_i`=1, `before_i`=0), base+4 for increment-before (1,1), base-4n+4 for decrement-after (0,0) and base-4n for decrement-before (0,1).
- R3: Each request after the first has an address 4 above the previous request and a higher register index.
- R4: On completion, `wb_value_o` is base+4n for increment modes and base-4n for decrement modes, for both the before and the after variant. `wb_strobe_o` is high during the `done_o` pulse only if `wb_en_i` was set at start.
- R5: `req_seq_o` is 0 on the first request of a transfer and 1 on every later one.
- R6: `req_write_o` is 1 for a store (`load_i`=0) and 0 for a load (`load_i`=1).
- R7: When `stack_en_i`=1, `incr_i` and `before_i` are ignored. `stack_kind_i` selects the stack type: 0 full descending, 1 full ascending, 2 empty descending, 3 empty ascending. A store (push) uses DB, IB, DA, IA for those types and a load (pop) uses IA, DA, IB, DB.
- R8: An all-zero mask issues no requests. `done_o` is high in the cycle after start, and `wb_value_o` equals the base.
- R9: While `req_valid_o` is high and `req_ready_i` is low, the request fields stay unchanged. The sequencer advances only on a beat where valid and ready are both high.
- R10: A start pulse while `busy_o` is high is ignored and does not alter the transfer in progress.
- R11: After reset `req_valid_o`, `busy_o` and `done_o` are low. For a non-empty mask, `busy_o` and `req_valid_o` rise in the cycle after start and stay high until the last beat is accepted. `done_o` is then a one-cycle pulse with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled when not busy |
| mask_i | input | 16 | Register selection mask |
| base_i | input | 32 | Base address |
| incr_i | input | 1 | 1 increment, 0 decrement |
| before_i | input | 1 | 1 step before, 0 step after |
| load_i | input | 1 | 1 load (pop), 0 store (push) |
| wb_en_i | input | 1 | Request base writeback |
| stack_en_i | input | 1 | Derive mode from stack type |
| stack_kind_i | input | 2 | Stack type code |
| req_ready_i | input | 1 | Memory accepts the request |
| req_valid_o | output | 1 | Request valid |
| req_addr_o | output | 32 | Word address |
| req_reg_o | output | 4 | Register index |
| req_write_o | output | 1 | 1 write, 0 read |
| req_seq_o | output | 1 | Sequential-cycle flag |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| wb_strobe_o | output | 1 | Base writeback strobe |
| wb_value_o | output | 32 | Updated base value |

## Verification
A wrong lowest-address plan shows on the first request, one cycle after start. A wrong remaining-mask update shows on the beat that follows as a skipped or repeated register index, or as a wrong number of beats before `done_o`. The bench stalls memory in regular and irregular patterns, so a sequencer that advances without a handshake produces an extra or early beat at once. Completion is compared against a base update computed independently, so an error in the count of selected registers appears in `wb_value_o` during the `done_o` pulse.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        STK_FULL_DESC  = 2'd0,
        STK_FULL_ASC   = 2'd1,
        STK_EMPTY_DESC = 2'd2,
        STK_EMPTY_ASC  = 2'd3
    } stack_kind_e;

endpackage

// File: rtl/blkxfer_mode_map.sv
module blkxfer_mode_map
    import blkxfer_pkg::*;
(
    input  logic       use_stack_i,
    input  logic [1:0] kind_i,
    input  logic       load_i,
    input  logic       incr_i,
    input  logic       before_i,
    output logic       incr_o,
    output logic       before_o
);
    // R7: a push is a store and a pop is a load; each stack type pairs opposite modes
    always_comb begin
        {incr_o, before_o} = {incr_i, before_i};
        if (use_stack_i) begin
            unique case (kind_i)
                STK_FULL_DESC:  {incr_o, before_o} = load_i ? 2'b10 : 2'b01;
                STK_FULL_ASC:   {incr_o, before_o} = load_i ? 2'b00 : 2'b11;
                STK_EMPTY_DESC: {incr_o, before_o} = load_i ? 2'b11 : 2'b00;
                default:        {incr_o, before_o} = load_i ? 2'b01 : 2'b10;
            endcase
        end
    end
endmodule

// File: rtl/blkxfer_addr_plan.sv
module blkxfer_addr_plan #(
    parameter int NREGS      = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [NREGS-1:0] mask_i,
    input  logic [AW-1:0]    base_i,
    input  logic             incr_i,
    input  logic             before_i,
    output logic [AW-1:0]    first_addr_o,
    output logic [AW-1:0]    wb_value_o,
    output logic             any_o
);
    localparam int CNTW  = $clog2(NREGS + 1);
    localparam int SHIFT = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [CNTW-1:0] count;
    logic [AW-1:0]   span;

    always_comb begin
        count = '0;
        for (int i = 0; i < NREGS; i++) begin
            count = count + CNTW'(mask_i[i]);
        end
        span = AW'(count) << SHIFT;
    end

    // R2, R4: lowest address first, base moves by the full span either way
    always_comb begin
        if (incr_i) begin
            first_addr_o = before_i ? base_i + STEP : base_i;
            wb_value_o   = base_i + span;
        end else begin
            first_addr_o = before_i ? base_i - span : base_i - span + STEP;
            wb_value_o   = base_i - span;
        end
    end

    assign any_o = |mask_i;
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
    parameter int NREGS = 16,
    parameter int IDXW  = $clog2(NREGS)
) (
    input  logic [NREGS-1:0] mask_i,
    output logic [IDXW-1:0]  idx_o,
    output logic [NREGS-1:0] rest_o
);
    logic [NREGS-1:0] isolate;

    assign rest_o  = mask_i & (mask_i - NREGS'(1));
    assign isolate = mask_i & ~(mask_i - NREGS'(1));

    for (genvar b = 0; b < IDXW; b++) begin : g_idx
        logic [NREGS-1:0] pick;
        always_comb begin
            for (int i = 0; i < NREGS; i++) begin
                pick[i] = isolate[i] && (((i >> b) & 1) != 0);
            end
        end
        assign idx_o[b] = |pick;
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int NREGS      = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NREGS-1:0]         mask_i,
    input  logic [AW-1:0]            base_i,
    input  logic                     incr_i,
    input  logic                     before_i,
    input  logic                     load_i,
    input  logic                     wb_en_i,
    input  logic                     stack_en_i,
    input  logic [1:0]               stack_kind_i,
    input  logic                     req_ready_i,
    output logic                     req_valid_o,
    output logic [AW-1:0]            req_addr_o,
    output logic [$clog2(NREGS)-1:0] req_reg_o,
    output logic                     req_write_o,
    output logic                     req_seq_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     wb_strobe_o,
    output logic [AW-1:0]            wb_value_o
);
    localparam int IDXW = $clog2(NREGS);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    typedef struct packed {
        seq_state_e       st;
        logic [NREGS-1:0] left;
        logic [AW-1:0]    addr;
        logic             seq;
        logic             wr;
        logic             wb_en;
        logic [AW-1:0]    wb_val;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;

    logic             eff_incr, eff_before;
    logic [AW-1:0]    plan_first, plan_wb;
    logic             plan_any;
    logic [IDXW-1:0]  low_idx;
    logic [NREGS-1:0] low_rest;

    blkxfer_mode_map u_mode (
        .use_stack_i (stack_en_i),
        .kind_i      (stack_kind_i),
        .load_i      (load_i),
        .incr_i      (incr_i),
        .before_i    (before_i),
        .incr_o      (eff_incr),
        .before_o    (eff_before)
    );

    blkxfer_addr_plan #(
        .NREGS      (NREGS),
        .AW         (AW),
        .WORD_BYTES (WORD_BYTES)
    ) u_plan (
        .mask_i       (mask_i),
        .base_i       (base_i),
        .incr_i       (eff_incr),
        .before_i     (eff_before),
        .first_addr_o (plan_first),
        .wb_value_o   (plan_wb),
        .any_o        (plan_any)
    );

    blkxfer_lowbit #(
        .NREGS (NREGS),
        .IDXW  (IDXW)
    ) u_low (
        .mask_i (regs_q.left),
        .idx_o  (low_idx),
        .rest_o (low_rest)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE, ST_DONE: begin
                regs_d.st = ST_IDLE;
                if (start_i) begin
                    regs_d.left   = mask_i;
                    regs_d.addr   = plan_first;
                    regs_d.seq    = 1'b0;
                    regs_d.wr     = !load_i;
                    regs_d.wb_en  = wb_en_i;
                    regs_d.wb_val = plan_wb;
                    regs_d.st     = plan_any ? ST_RUN : ST_DONE;
                end
            end
            ST_RUN: begin
                // R10: start_i is not looked at here
                if (req_ready_i) begin
                    regs_d.left = low_rest;
                    regs_d.addr = regs_q.addr + STEP;
                    regs_d.seq  = 1'b1;
                    if (low_rest == '0) begin
                        regs_d.st = ST_DONE;
                    end
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_valid_o = (regs_q.st == ST_RUN);
    assign req_addr_o  = regs_q.addr;
    assign req_reg_o   = low_idx;
    assign req_write_o = regs_q.wr;
    assign req_seq_o   = regs_q.seq;
    assign busy_o      = (regs_q.st == ST_RUN);
    assign done_o      = (regs_q.st == ST_DONE);
    assign wb_strobe_o = done_o && regs_q.wb_en;
    assign wb_value_o  = regs_q.wb_val;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
            && $stable(req_reg_o) && $stable(req_write_o) && $stable(req_seq_o)); // R9

    AST_ADDR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i |=> !req_valid_o
            || (req_addr_o == $past(req_addr_o) + STEP && req_reg_o > $past(req_reg_o))); // R3

    AST_SEQ_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_ready_i |=> !req_valid_o || req_seq_o); // R5

    AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> !req_seq_o); // R5

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R11

    AST_STROBE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_strobe_o |-> done_o); // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !req_ready_i |=> busy_o && $stable(req_addr_o)); // R10
endmodule

// File: tb/blkxfer_seq_test.sv
`timescale 1ns/1ps
module blkxfer_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [31:0] base_i = '0;
    logic        incr_i = 1'b0, before_i = 1'b0, load_i = 1'b0, wb_en_i = 1'b0;
    logic        stack_en_i = 1'b0;
    logic [1:0]  stack_kind_i = '0;
    logic        req_ready_i = 1'b0;
    logic        req_valid_o, req_write_o, req_seq_o, busy_o, done_o, wb_strobe_o;
    logic [31:0] req_addr_o, wb_value_o;
    logic [3:0]  req_reg_o;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  rg;
        logic        wr;
        logic        sq;
    } beat_t;
    typedef struct packed {
        logic [31:0] wbv;
        logic        stb;
    } fin_t;

    beat_t bq[$];
    fin_t  fq[$];
    int    n_tests = 0;
    int    n_fail = 0;
    int    stall_mode = 0;
    string first_tag = "R2";
    bit    finished = 1'b0;

    always #2 clk = ~clk;

    blkxfer_seq uut (
        .clk, .rst_n, .start_i, .mask_i, .base_i, .incr_i, .before_i,
        .load_i, .wb_en_i, .stack_en_i, .stack_kind_i, .req_ready_i,
        .req_valid_o, .req_addr_o, .req_reg_o, .req_write_o, .req_seq_o,
        .busy_o, .done_o, .wb_strobe_o, .wb_value_o
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: drives ready, checks beats and completions against the queues
    initial begin
        int    cyc = 0;
        logic [7:0] lfsr = 8'hA5;
        bit    prev_stall = 1'b0;
        beat_t prev_b = '0;
        forever begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            case (stall_mode)
                0: req_ready_i = 1'b1;
                1: req_ready_i = cyc[0];
                default: req_ready_i = lfsr[0] | lfsr[2];
            endcase
            if (!rst_n) continue;
            if (prev_stall) begin
                chk(req_valid_o && req_addr_o == prev_b.addr && req_reg_o == prev_b.rg
                    && req_seq_o == prev_b.sq && req_write_o == prev_b.wr,
                    "R9", "held request", req_addr_o, prev_b.addr);
            end
            prev_stall = req_valid_o && !req_ready_i;
            prev_b = '{addr: req_addr_o, rg: req_reg_o, wr: req_write_o, sq: req_seq_o};
            if (req_valid_o && req_ready_i) begin
                if (bq.size() == 0) begin
                    chk(1'b0, "R1", "unexpected request reg", 32'(req_reg_o), 32'hFFFF_FFFF);
                end else begin
                    beat_t e;
                    e = bq.pop_front();
                    chk(req_reg_o == e.rg, "R1", "register index", 32'(req_reg_o), 32'(e.rg));
                    chk(req_addr_o == e.addr, e.sq ? "R3" : first_tag, "address", req_addr_o, e.addr);
                    chk(req_seq_o == e.sq, "R5", "sequential flag", 32'(req_seq_o), 32'(e.sq));
                    chk(req_write_o == e.wr, "R6", "write flag", 32'(req_write_o), 32'(e.wr));
                end
            end
            if (done_o) begin
                chk(!busy_o, "R11", "busy during done", 32'(busy_o), 32'd0);
                chk(bq.size() == 0, "R1", "beats missing at done", 32'(bq.size()), 32'd0);
                bq.delete();
                if (fq.size() == 0) begin
                    chk(1'b0, "R11", "unexpected done", 32'd1, 32'd0);
                end else begin
                    fin_t f;
                    f = fq.pop_front();
                    chk(wb_value_o == f.wbv, "R4", "writeback value", wb_value_o, f.wbv);
                    chk(wb_strobe_o == f.stb, "R4", "writeback strobe", 32'(wb_strobe_o), 32'(f.stb));
                end
            end
        end
    end

    // Driver: computes expected beats and completion, then starts the transfer
    task automatic run_xfer(input logic [15:0] m, input logic [31:0] b,
                            input logic inc, input logic bef, input logic ld,
                            input logic we, input logic se, input logic [1:0] kd,
                            input bit poke_busy);
        logic ei, eb;
        logic [31:0] n4, lo, wbv;
        int k;
        {ei, eb} = {inc, bef};
        if (se) begin
            // R7 mapping: kind 0 FD, 1 FA, 2 ED, 3 EA; store push, load pop
            case (kd)
                2'd0: {ei, eb} = ld ? 2'b10 : 2'b01;
                2'd1: {ei, eb} = ld ? 2'b00 : 2'b11;
                2'd2: {ei, eb} = ld ? 2'b11 : 2'b00;
                default: {ei, eb} = ld ? 2'b01 : 2'b10;
            endcase
        end
        n4 = 32'($countones(m)) * 32'd4;
        if (ei) begin
            lo  = eb ? b + 32'd4 : b;
            wbv = b + n4;
        end else begin
            lo  = eb ? b - n4 : b - n4 + 32'd4;
            wbv = b - n4;
        end
        first_tag = se ? "R7" : "R2";
        while (busy_o || done_o) @(negedge clk);
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                bq.push_back('{addr: lo + 32'(k) * 32'd4, rg: 4'(i), wr: !ld, sq: (k != 0)});
                k++;
            end
        end
        fq.push_back('{wbv: wbv, stb: we});
        mask_i = m; base_i = b; incr_i = inc; before_i = bef; load_i = ld;
        wb_en_i = we; stack_en_i = se; stack_kind_i = kd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (m == '0) begin
            chk(done_o && !req_valid_o, "R8", "empty mask done next cycle", 32'(done_o), 32'd1);
        end else begin
            chk(busy_o && req_valid_o, "R11", "busy after start", 32'(busy_o), 32'd1);
        end
        if (poke_busy) begin
            // R10: start with different inputs while busy must be ignored
            mask_i = 16'hFFFF; base_i = 32'hDEAD_0000; incr_i = ~inc; load_i = ~ld;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o, "R10", "still busy after ignored start", 32'(busy_o), 32'd1);
        end
        while (fq.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid_o && !busy_o && !done_o, "R11", "reset state",
            {29'd0, req_valid_o, busy_o, done_o}, 32'd0);

        stall_mode = 0;
        run_xfer(16'h053A, 32'h0000_1000, 1, 0, 0, 1, 0, 0, 0); // IA store
        run_xfer(16'h053A, 32'h0000_1000, 1, 1, 1, 1, 0, 0, 0); // IB load
        run_xfer(16'h053A, 32'h0000_1000, 0, 0, 0, 1, 0, 0, 0); // DA store
        run_xfer(16'h053A, 32'h0000_1000, 0, 1, 1, 1, 0, 0, 0); // DB load
        run_xfer(16'h0081, 32'h0000_2000, 0, 1, 0, 0, 0, 0, 0); // R4 no strobe
        run_xfer(16'h8000, 32'h0000_3000, 1, 1, 1, 1, 0, 0, 0); // single R15
        run_xfer(16'h0000, 32'h0000_4444, 0, 1, 0, 1, 0, 0, 0); // R8
        run_xfer(16'h0000, 32'h0000_5550, 1, 0, 1, 0, 0, 0, 0); // R8

        stall_mode = 1;
        run_xfer(16'hFFFF, 32'h0000_0040, 0, 0, 1, 1, 0, 0, 0); // wrap, stalls R9
        run_xfer(16'h0F0F, 32'h0000_6000, 1, 0, 0, 1, 0, 0, 1); // R10

        stall_mode = 2;
        for (int kd = 0; kd < 4; kd++) begin
            run_xfer(16'h8421, 32'h0000_8000, 1'b0, 1'b0, 1'b0, 1, 1, 2'(kd), 0); // R7 push
            run_xfer(16'h8421, 32'h0000_8000, 1'b1, 1'b1, 1'b1, 1, 1, 2'(kd), 0); // R7 pop
        end
        run_xfer(16'h6C03, 32'h0001_0000, 0, 1, 0, 1, 0, 0, 0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule